// File: doc/BRIEF.md
# Tree-Summarised Interrupt Controller with Windowed Configuration

This block collects 256 interrupt lines and turns them into a single summary interrupt. The lines are grouped eight to a block, and the 32 blocks are grouped eight to a master, so the pending state forms a three-level tree. A root register shows which masters have work. A status register per master shows which of its blocks have work. The block pending register, read through a block-select window, shows which lines of the chosen block have work. Software walks the tree from the root down to find the source.

Each line has its own detector. It can run in edge mode, with rising and falling edges masked separately, or in level mode, with an active-high or active-low sense. Software never addresses a line directly. It first writes the block-select register. It then writes a configuration byte whose top bit arms the write and whose index field names the line inside the selected block. The same window gives a read of the synchronised live levels of the selected block. Access is through a plain synchronous register bus with a 10-bit address and 8-bit data. Read data arrives one cycle after the read strobe.

Top module: `irq_tree_ctrl`

## Requirements
- R1: Line n sits in block n/8 at bit n%8. Writing block select (base+5) keeps the low 5 bits, reads back as `{3'b0, sel}`, and holds its value until the next write to base+5. Reading base+6 returns the pending flags of the selected block, with bit k standing for line sel*8+k.
- R2: The root register (base+0) reports master m at bit m+1, set when any block of that master has a pending line. Bit 0 always reads 0.
- R3: Master status register m (base+1+m, m = 0..3) has bit i set when block m*8+i has any pending line. `irq_out` is high exactly when some line is pending.
- R4: In edge mode (config bit 0 = 0), an unmasked edge sets the pending flag. The flag stays set, even after the input returns, until a configuration write to that line carries the clear bit (bit 3).
- R5: Config bit 1 masks falling edges and bit 2 masks rising edges. In edge mode with both set, no edge ever sets the flag. With both clear, either edge sets it.
- R6: In level mode (config bit 0 = 1), the pending flag follows the synchronised input. It is high while the input is high if bit 2 is clear, and high while the input is low if bit 1 is clear.
- R7: A write to base+7 changes a line's settings only when bit 7 is 1. Bits 6:4 select the line within the selected block.
- R8: Reading base+8 returns the synchronised (two-flop) levels of the selected block's inputs, with bit k standing for line sel*8+k.
- R9: Writes to base+0, base+1..4, base+6 and base+8 have no effect. Reads of base+7 and of any address outside base+0..base+8 return 0.
- R10: After reset, every line is in edge mode with both masks set, no line is pending, block select is 0 and `irq_out` is low.
- R11: A read strobe at one rising edge produces `rd_valid` high with `rd_data` at the following edge. The data reflects the state at the strobe edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in | input | 256 | Asynchronous interrupt lines |
| bus_addr | input | 10 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe |
| rd_data | output | 8 | Read data, valid with rd_valid |
| rd_valid | output | 1 | Read data valid |
| irq_out | output | 1 | Summary interrupt |

## Verification
The assertions assume two things about the bus: a read and a write are never strobed in the same cycle, and the address is held for the whole strobe cycle. The driver tasks issue exactly one access per cycle and then release both strobes.

The edge and level properties also assume that each input stays at a value for at least one full clock period. For this reason the stimulus holds every level for several cycles before it changes the line again or reads the result. With that spacing, the two synchroniser stages and the pending register have settled before each scoreboard compare.

// File: rtl/irq_tree_pkg.sv
// Package: register offsets and configuration-byte field positions shared
// by the interrupt controller. Assumes offsets are relative to the base.
package irq_tree_pkg;
    // offsets from the base address
    localparam int OFS_ROOT = 0;
    localparam int OFS_MST0 = 1;
    localparam int OFS_SEL  = 5;
    localparam int OFS_PEND = 6;
    localparam int OFS_CFG  = 7;
    localparam int OFS_LIVE = 8;
    localparam int OFS_LAST = 8;
    // configuration byte fields
    localparam int CFG_LVL    = 0;
    localparam int CFG_MFE    = 1;
    localparam int CFG_MRE    = 2;
    localparam int CFG_CLR    = 3;
    localparam int CFG_IDX_LO = 4;
    localparam int CFG_ARM    = 7;
endpackage

// File: rtl/irq_cell.sv
// Module: one interrupt line. It synchronises the input, keeps the line's
// mode and masks, and holds the pending flag. Assumes cfg_we_i is a
// single-cycle pulse that is already decoded for this line.
module irq_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    input  logic cfg_we_i,
    input  logic cfg_lvl_i,
    input  logic cfg_mfe_i,
    input  logic cfg_mre_i,
    input  logic cfg_clr_i,
    output logic live_o,
    output logic pend_o
);
    logic sync1_q, sync2_q, prev_q;
    logic lvl_q, mfe_q, mre_q, pend_q;
    logic rise_hit, fall_hit, level_hit, clr_hit;

    // two-flop synchroniser plus a delayed copy for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1_q <= 1'b0;
            sync2_q <= 1'b0;
            prev_q  <= 1'b0;
        end else begin
            sync1_q <= raw_i;
            sync2_q <= sync1_q;
            prev_q  <= sync2_q;
        end
    end

    // per-line mode and masks; reset leaves the line fully masked
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q <= 1'b0;
            mfe_q <= 1'b1;
            mre_q <= 1'b1;
        end else if (cfg_we_i) begin
            lvl_q <= cfg_lvl_i;
            mfe_q <= cfg_mfe_i;
            mre_q <= cfg_mre_i;
        end
    end

    // detector terms for the current settings
    always_comb begin
        rise_hit  = sync2_q & ~prev_q & ~mre_q;
        fall_hit  = ~sync2_q & prev_q & ~mfe_q;
        level_hit = (sync2_q & ~mre_q) | (~sync2_q & ~mfe_q);
        clr_hit   = cfg_we_i & cfg_clr_i;
    end

    // pending flag: tracks the level in level mode, latches edges otherwise
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend_q <= 1'b0;
        else if (lvl_q)
            pend_q <= level_hit;
        else
            pend_q <= (pend_q & ~clr_hit) | rise_hit | fall_hit;
    end

    assign live_o = sync2_q;
    assign pend_o = pend_q;

    AST_MASKED_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (mfe_q && mre_q) |=> !$rose(pend_q)); // R5
    AST_EDGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!lvl_q && pend_q && !clr_hit) |=> pend_q); // R4
endmodule

// File: rtl/irq_summary.sv
// Module: reduces the pending flags into a per-block flag, a per-master
// flag and one summary output. Purely combinational; assumes blocks are
// numbered so that master m owns blocks m*BLK_PER_MST and up.
module irq_summary #(
    parameter int NBLK        = 32,
    parameter int BLK_W       = 8,
    parameter int BLK_PER_MST = 8,
    parameter int NMST        = NBLK / BLK_PER_MST
) (
    input  logic [NBLK-1:0][BLK_W-1:0] pend_i,
    output logic [NBLK-1:0]            blk_any_o,
    output logic [NMST-1:0]            mst_any_o,
    output logic                       irq_o
);
    // block level: any line of the block pending
    for (genvar b = 0; b < NBLK; b++) begin : g_blk
        assign blk_any_o[b] = |pend_i[b];
    end

    // master level: any block of the master pending
    for (genvar m = 0; m < NMST; m++) begin : g_mst
        assign mst_any_o[m] = |blk_any_o[m*BLK_PER_MST +: BLK_PER_MST];
    end

    assign irq_o = |mst_any_o;
endmodule

// File: rtl/irq_tree_ctrl.sv
// Module: top of the interrupt controller. It decodes the register window,
// holds block select, fans configuration writes out to the lines and
// registers the read data. Assumes read and write strobes never coincide.
module irq_tree_ctrl #(
    parameter int N_IRQ       = 256,
    parameter int BLK_W       = 8,
    parameter int BLK_PER_MST = 8,
    parameter int ADDR_W      = 10,
    parameter int DATA_W      = 8,
    parameter logic [ADDR_W-1:0] BASE = 10'h1BB
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_IRQ-1:0]  irq_in,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_rd,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              irq_out
);
    import irq_tree_pkg::*;

    localparam int NBLK  = N_IRQ / BLK_W;
    localparam int NMST  = NBLK / BLK_PER_MST;
    localparam int SEL_W = $clog2(NBLK);
    localparam int BIT_W = $clog2(BLK_W);
    localparam logic [ADDR_W-1:0] A_ROOT = ADDR_W'(OFS_ROOT);
    localparam logic [ADDR_W-1:0] A_SEL  = ADDR_W'(OFS_SEL);
    localparam logic [ADDR_W-1:0] A_PEND = ADDR_W'(OFS_PEND);
    localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(OFS_CFG);
    localparam logic [ADDR_W-1:0] A_LIVE = ADDR_W'(OFS_LIVE);
    localparam logic [ADDR_W-1:0] A_LAST = ADDR_W'(OFS_LAST);

    logic [ADDR_W-1:0]          ofs;
    logic                       in_win;
    logic [SEL_W-1:0]           sel_q;
    logic                       cfg_we;
    logic [BIT_W-1:0]           cfg_idx;
    logic [NBLK-1:0][BLK_W-1:0] pend_v;
    logic [NBLK-1:0][BLK_W-1:0] live_v;
    logic [NBLK-1:0]            blk_any;
    logic [NMST-1:0]            mst_any;
    logic [DATA_W-1:0]          rd_mux;

    // address window decode
    always_comb begin
        ofs     = bus_addr - BASE;
        in_win  = (bus_addr >= BASE) && (ofs <= A_LAST);
        cfg_we  = bus_wr && in_win && (ofs == A_CFG) && bus_wdata[CFG_ARM];
        cfg_idx = bus_wdata[CFG_IDX_LO +: BIT_W];
    end

    // block-select register
    always_ff @(posedge clk) begin
        if (!rst_n)
            sel_q <= '0;
        else if (bus_wr && in_win && ofs == A_SEL)
            sel_q <= bus_wdata[SEL_W-1:0];
    end

    // one detector per line, addressed by block and bit
    for (genvar b = 0; b < NBLK; b++) begin : g_b
        for (genvar k = 0; k < BLK_W; k++) begin : g_k
            irq_cell u_cell (
                .clk       (clk),
                .rst_n     (rst_n),
                .raw_i     (irq_in[b*BLK_W + k]),
                .cfg_we_i  (cfg_we && (sel_q == SEL_W'(b)) && (cfg_idx == BIT_W'(k))),
                .cfg_lvl_i (bus_wdata[CFG_LVL]),
                .cfg_mfe_i (bus_wdata[CFG_MFE]),
                .cfg_mre_i (bus_wdata[CFG_MRE]),
                .cfg_clr_i (bus_wdata[CFG_CLR]),
                .live_o    (live_v[b][k]),
                .pend_o    (pend_v[b][k])
            );
        end
    end

    irq_summary #(
        .NBLK        (NBLK),
        .BLK_W       (BLK_W),
        .BLK_PER_MST (BLK_PER_MST),
        .NMST        (NMST)
    ) u_summary (
        .pend_i    (pend_v),
        .blk_any_o (blk_any),
        .mst_any_o (mst_any),
        .irq_o     (irq_out)
    );

    // read multiplexer over the window
    always_comb begin
        rd_mux = '0;
        if (in_win) begin
            if (ofs == A_ROOT)
                rd_mux[NMST:1] = mst_any;
            for (int m = 0; m < NMST; m++)
                if (ofs == ADDR_W'(OFS_MST0 + m))
                    rd_mux = blk_any[m*BLK_PER_MST +: BLK_PER_MST];
            if (ofs == A_SEL)
                rd_mux = DATA_W'(sel_q);
            if (ofs == A_PEND)
                rd_mux = pend_v[sel_q];
            if (ofs == A_LIVE)
                rd_mux = live_v[sel_q];
        end
    end

    // registered read response
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= bus_rd;
            rd_data  <= bus_rd ? rd_mux : '0;
        end
    end

    AST_IRQ_OUT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out == (|pend_v)); // R3
    AST_SEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == BASE + A_SEL) |=> $stable(sel_q)); // R1
    AST_RD_RESPONSE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |=> rd_valid); // R11
    AST_ROOT_LSB_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == BASE) |=> !rd_data[0]); // R2
endmodule

// File: tb/tb_irq_tree_ctrl.sv
module tb_irq_tree_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam logic [9:0] BASE = 10'h1BB;

    typedef struct {
        logic [7:0] exp;
        string      tag;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [255:0] irq_in = '0;
    logic [9:0]   bus_addr = '0;
    logic         bus_wr = 1'b0;
    logic [7:0]   bus_wdata = '0;
    logic         bus_rd = 1'b0;
    logic [7:0]   rd_data;
    logic         rd_valid;
    logic         irq_out;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    exp_t sb_q[$];

    irq_tree_ctrl dut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rd(bus_rd),
        .rd_data(rd_data), .rd_valid(rd_valid), .irq_out(irq_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic wr(input logic [9:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    // driver: issue a read and push its expected value to the scoreboard
    task automatic rd_expect(input logic [9:0] a, input logic [7:0] e, input string tag);
        exp_t it;
        @(negedge clk);
        it.exp = e; it.tag = tag;
        sb_q.push_back(it);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic cfg(input int n, input logic [7:0] bits);
        wr(BASE + 10'd5, 8'(n / 8));
        wr(BASE + 10'd7, 8'h80 | 8'((n % 8) << 4) | bits);
    endtask

    task automatic settle();
        repeat (6) @(negedge clk);
    endtask

    task automatic chk_irq(input logic e, input string tag);
        @(negedge clk);
        checks++;
        if (irq_out !== e) begin
            failures++;
            $display("FAIL %s irq_out actual=%0b expected=%0b", tag, irq_out, e);
        end
    endtask

    // monitor: compare each read response with the oldest expectation
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            checks++;
            if (sb_q.size() == 0) begin
                failures++;
                $display("FAIL R11 unexpected response actual=%02h expected=none", rd_data);
            end else begin
                exp_t it;
                it = sb_q.pop_front();
                if (rd_data !== it.exp) begin
                    failures++;
                    $display("FAIL %s actual=%02h expected=%02h", it.tag, rd_data, it.exp);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // reset state
        chk_irq(1'b0, "R10");
        rd_expect(BASE, 8'h00, "R10 root");
        rd_expect(BASE + 10'd5, 8'h00, "R10 sel");
        rd_expect(BASE + 10'd6, 8'h00, "R10 pend");
        // edge rising on line 5, falling masked
        cfg(5, 8'h02);
        irq_in[5] = 1'b1; settle();
        rd_expect(BASE + 10'd6, 8'h20, "R4 pend line5");
        rd_expect(BASE, 8'h02, "R2 root master0");
        rd_expect(BASE + 10'd1, 8'h01, "R3 master0 block0");
        chk_irq(1'b1, "R3");
        irq_in[5] = 1'b0; settle();
        rd_expect(BASE + 10'd6, 8'h20, "R4 held after return");
        wr(BASE + 10'd7, 8'hDA);
        settle();
        rd_expect(BASE + 10'd6, 8'h00, "R4 cleared");
        rd_expect(BASE, 8'h00, "R2 root empty");
        chk_irq(1'b0, "R3");
        // both masks set
        cfg(5, 8'h06);
        irq_in[5] = 1'b1; settle();
        irq_in[5] = 1'b0; settle();
        rd_expect(BASE + 10'd6, 8'h00, "R5 fully masked");
        // line 40, both edges unmasked
        cfg(40, 8'h00);
        irq_in[40] = 1'b1; settle();
        rd_expect(BASE + 10'd6, 8'h01, "R5 rise line40");
        rd_expect(BASE + 10'd1, 8'h20, "R3 master0 block5");
        wr(BASE + 10'd7, 8'h88); settle();
        rd_expect(BASE + 10'd6, 8'h00, "R4 clear line40");
        irq_in[40] = 1'b0; settle();
        rd_expect(BASE + 10'd6, 8'h01, "R5 fall line40");
        wr(BASE + 10'd7, 8'h88); settle();
        rd_expect(BASE + 10'd6, 8'h00, "R4 clear line40 again");
        // unarmed write to line 41 must not unmask it
        wr(BASE + 10'd7, 8'h10);
        irq_in[41] = 1'b1; settle();
        irq_in[41] = 1'b0; settle();
        rd_expect(BASE + 10'd6, 8'h00, "R7 unarmed write");
        // level high on line 200
        cfg(200, 8'h03); settle();
        rd_expect(BASE + 10'd6, 8'h00, "R6 level high idle");
        irq_in[200] = 1'b1; settle();
        rd_expect(BASE + 10'd6, 8'h01, "R6 level high active");
        rd_expect(BASE, 8'h10, "R2 root master3");
        rd_expect(BASE + 10'd4, 8'h02, "R3 master3 block25");
        irq_in[200] = 1'b0; settle();
        rd_expect(BASE + 10'd6, 8'h00, "R6 level high released");
        chk_irq(1'b0, "R6");
        // level low on line 201
        cfg(201, 8'h05); settle();
        rd_expect(BASE + 10'd6, 8'h02, "R6 level low active");
        irq_in[201] = 1'b1; settle();
        rd_expect(BASE + 10'd6, 8'h00, "R6 level low released");
        // live levels
        irq_in[207:200] = 8'hA5; settle();
        rd_expect(BASE + 10'd8, 8'hA5, "R8 live block25");
        irq_in[207:200] = 8'h02; settle();
        rd_expect(BASE + 10'd8, 8'h02, "R8 live block25 second");
        // ignored writes, with line 5 made pending first
        cfg(5, 8'h02);
        irq_in[5] = 1'b1; settle();
        wr(BASE, 8'h00);
        wr(BASE + 10'd1, 8'h00);
        wr(BASE + 10'd6, 8'h00);
        wr(BASE + 10'd8, 8'h00);
        settle();
        rd_expect(BASE, 8'h02, "R9 root after writes");
        rd_expect(BASE + 10'd6, 8'h20, "R9 pend after writes");
        rd_expect(BASE + 10'd8, 8'h20, "R9 live after writes");
        // unmapped and write-only reads
        rd_expect(10'h000, 8'h00, "R9 unmapped low");
        rd_expect(BASE + 10'd9, 8'h00, "R9 unmapped high");
        rd_expect(BASE + 10'd7, 8'h00, "R9 config read");
        // select width
        wr(BASE + 10'd5, 8'hE3);
        rd_expect(BASE + 10'd5, 8'h03, "R1 select low bits");
        repeat (4) @(negedge clk);
        checks++;
        if (sb_q.size() != 0) begin
            failures++;
            $display("FAIL R11 missing responses actual=%0d expected=0", sb_q.size());
        end
        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule